// File: doc/BRIEF.md
# Bit-Plane Population Erasure Filter

This block cleans one code block of high-frequency wavelet coefficient magnitudes after they are read back from a memory that may have flipped bits. In a natural image the high sub-bands (HL, LH, HH) hold small magnitudes. A sparse scattering of ones in an upper bit plane is therefore much more likely to be memory damage than signal. The filter walks the bit planes from the top down. For each plane it counts how many coefficients have that bit set, and it clears the whole plane when the count is below a threshold supplied by the caller. The caller sets that threshold to roughly twice the expected number of memory errors per plane.

The block works on an external coefficient buffer. It reads through a synchronous port that returns data one cycle after the request, and it writes back through a separate write port. A one-cycle `start` pulse launches a run and latches the threshold. The scan ends for good at the first plane that is kept. Every plane cleared up to that point is reported as all-zero on a per-plane mask, so the downstream entropy coder can skip it. A single write-back pass then clears those planes in the buffer, and `done` pulses once at the end.

Top module: `bit_plane_eraser`

## Requirements
- R1: After reset, `done`, `buf_rd_en` and `buf_wr_en` are low and `zero_planes` is all zeros.
- R2: The threshold is sampled only in the cycle `start` is seen while idle. Changing `thresh`, or pulsing `start` again while a run is in progress, has no effect on that run.
- R3: Planes are examined from bit DW-1 downward. For each plane the set bits at that position are counted over all ROWS*COLS coefficients, and the plane is erased when the count is strictly below the latched threshold.
- R4: Scanning stops at the first plane whose count is not below the threshold. That plane and every lower plane keep their bits in the buffer, even if a lower plane would itself qualify, so the erased planes always form a contiguous run from the MSB.
- R5: The population counter is CNT_W bits wide and saturates at 2^CNT_W-1. A saturated count never leads to erasure, whatever the coefficient count.
- R6: Bit p of `zero_planes` is 1 exactly when plane p was erased. It is cleared at `start` and holds its value from `done` until the next accepted `start`.
- R7: When at least one plane is erased, every buffer location is written exactly once with the erased bits cleared and all other bits unchanged. When no plane is erased, no write occurs.
- R8: `done` is high for exactly one cycle, after the last write of the run, with `zero_planes` already final. No write occurs after it.
- R9: A threshold of 0 erases nothing. If every plane is below the threshold, all DW planes are erased and the scan ends after plane 0.
- R10: A read request (`buf_rd_en` with `buf_rd_addr`) is answered on `buf_rd_data` in the following cycle. The block consumes the data in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launches a run when idle |
| thresh | input | CNT_W | Erase threshold, latched at start |
| buf_rd_en | output | 1 | Buffer read request |
| buf_rd_addr | output | $clog2(ROWS*COLS) | Buffer read address |
| buf_rd_data | input | DW | Read data, one cycle after the request |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wr_addr | output | $clog2(ROWS*COLS) | Buffer write address |
| buf_wr_data | output | DW | Coefficient with erased planes cleared |
| done | output | 1 | One-cycle end-of-run pulse |
| zero_planes | output | DW | Per-plane all-zero flags, bit p for plane p |

## Verification
The hardest situation to reach is a second `start` arriving together with a changed threshold while a run is already in progress. A design that wrongly restarts would then produce a different mask and extra writes. The bench reaches it by changing `thresh` right after launch and pulsing `start` both during the counting passes and in the first write-back cycle. Counter saturation is the other hard case. The bench reaches it with a small CNT_W and a plane that is fully populated, so a wrapping counter would fall below the threshold and wrongly erase the plane.

// File: rtl/bpe_pkg.sv
package bpe_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COUNT,
        ST_DECIDE,
        ST_WRITE,
        ST_DONE
    } bpe_state_e;
endpackage

// File: rtl/bpe_addr_seq.sv
module bpe_addr_seq #(
    parameter int N = 1024
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch,
    output logic                 rd_en,
    output logic [$clog2(N)-1:0] rd_addr,
    output logic                 beat_vld,
    output logic [$clog2(N)-1:0] beat_addr,
    output logic                 beat_last
);
    localparam int AW = $clog2(N);
    localparam logic [AW-1:0] LAST = AW'(N - 1);

    typedef struct packed {
        logic          issue;
        logic [AW-1:0] addr;
        logic          pend;
        logic [AW-1:0] paddr;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.pend  = s_q.issue;
        s_d.paddr = s_q.addr;
        if (launch) begin
            s_d.issue = 1'b1;
            s_d.addr  = '0;
        end else if (s_q.issue) begin
            if (s_q.addr == LAST) s_d.issue = 1'b0;
            else                  s_d.addr  = s_q.addr + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_en     = s_q.issue;
    assign rd_addr   = s_q.addr;
    assign beat_vld  = s_q.pend;
    assign beat_addr = s_q.paddr;
    assign beat_last = s_q.pend && (s_q.paddr == LAST);

    // R10: data is consumed only one cycle after a matching request
    assert_beat_after_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld |-> ($past(rd_en) && beat_addr == $past(rd_addr)));

    // R10: a new pass is never launched while reads are still in flight
    assert_launch_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (!rd_en && !beat_vld));
endmodule

// File: rtl/bpe_pop_ctr.sv
module bpe_pop_ctr #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] thr,
    output logic [CNT_W-1:0] cnt,
    output logic             below
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                        cnt_d = '0;
        else if (inc && cnt_q != CMAX)  cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt   = cnt_q;
    assign below = cnt_q < thr;

    // R5: once saturated the count stays at its ceiling until cleared
    assert_sat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CMAX && !clr) |=> (cnt_q == CMAX));

    // R5: without a clear the count never wraps downward
    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/bit_plane_eraser.sv
module bit_plane_eraser #(
    parameter int ROWS  = 32,
    parameter int COLS  = 32,
    parameter int DW    = 16,
    parameter int CNT_W = 9
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [CNT_W-1:0]             thresh,
    output logic                         buf_rd_en,
    output logic [$clog2(ROWS*COLS)-1:0] buf_rd_addr,
    input  logic [DW-1:0]                buf_rd_data,
    output logic                         buf_wr_en,
    output logic [$clog2(ROWS*COLS)-1:0] buf_wr_addr,
    output logic [DW-1:0]                buf_wr_data,
    output logic                         done,
    output logic [DW-1:0]                zero_planes
);
    import bpe_pkg::*;

    localparam int N  = ROWS * COLS;
    localparam int AW = $clog2(N);
    localparam int PW = $clog2(DW);
    localparam logic [PW-1:0] TOP_PLANE = PW'(DW - 1);

    typedef struct packed {
        bpe_state_e       state;
        logic [PW-1:0]    plane;
        logic [CNT_W-1:0] thr;
        logic [DW-1:0]    mask;
    } ctl_t;

    ctl_t c_d, c_q;

    logic          launch, clr, inc;
    logic          beat_vld, beat_last;
    logic [AW-1:0] beat_addr;
    logic [CNT_W-1:0] cnt;
    logic          below;

    bpe_addr_seq #(.N(N)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .rd_en     (buf_rd_en),
        .rd_addr   (buf_rd_addr),
        .beat_vld  (beat_vld),
        .beat_addr (beat_addr),
        .beat_last (beat_last)
    );

    bpe_pop_ctr #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (inc),
        .thr   (c_q.thr),
        .cnt   (cnt),
        .below (below)
    );

    always_comb begin
        c_d    = c_q;
        launch = 1'b0;
        clr    = 1'b0;
        inc    = 1'b0;
        unique case (c_q.state)
            ST_IDLE: begin
                if (start) begin
                    c_d.state = ST_COUNT;
                    c_d.thr   = thresh;
                    c_d.mask  = '0;
                    c_d.plane = TOP_PLANE;
                    launch    = 1'b1;
                    clr       = 1'b1;
                end
            end
            ST_COUNT: begin
                inc = beat_vld && buf_rd_data[c_q.plane];
                if (beat_last) c_d.state = ST_DECIDE;
            end
            ST_DECIDE: begin
                if (below) begin
                    c_d.mask[c_q.plane] = 1'b1;
                    launch = 1'b1;
                    if (c_q.plane == '0) begin
                        c_d.state = ST_WRITE;
                    end else begin
                        c_d.plane = c_q.plane - PW'(1);
                        c_d.state = ST_COUNT;
                        clr       = 1'b1;
                    end
                end else if (c_q.mask == '0) begin
                    c_d.state = ST_DONE;
                end else begin
                    c_d.state = ST_WRITE;
                    launch    = 1'b1;
                end
            end
            ST_WRITE: begin
                if (beat_last) c_d.state = ST_DONE;
            end
            ST_DONE: c_d.state = ST_IDLE;
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.state <= ST_IDLE;
            c_q.plane <= '0;
            c_q.thr   <= '0;
            c_q.mask  <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign buf_wr_en   = (c_q.state == ST_WRITE) && beat_vld;
    assign buf_wr_addr = beat_addr;
    assign buf_wr_data = buf_rd_data & ~c_q.mask;
    assign done        = (c_q.state == ST_DONE);
    assign zero_planes = c_q.mask;

    // R8: end-of-run strobe lasts a single cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: no write is issued in the cycle of the end strobe
    assert_no_write_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !buf_wr_en);

    // R4: erased planes form one contiguous run starting at the MSB
    assert_mask_contig_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (((~zero_planes) & ((~zero_planes) + DW'(1))) == '0));

    // R4: during a run the mask only gains planes
    assert_mask_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state != ST_IDLE) |=> ((zero_planes & $past(zero_planes)) == $past(zero_planes)));

    // R6: with no accepted start the reported mask holds
    assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_IDLE && !start) |=> $stable(zero_planes));

    // R2: the latched threshold cannot move while a run is active
    assert_thr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state != ST_IDLE) |=> $stable(c_q.thr));
endmodule

// File: tb/bit_plane_eraser_test.sv
module bit_plane_eraser_test;
    localparam int ROWS  = 4;
    localparam int COLS  = 4;
    localparam int N     = ROWS * COLS;
    localparam int AW    = $clog2(N);
    localparam int DW    = 16;
    localparam int CNT_W = 3;
    localparam int CMAX  = (1 << CNT_W) - 1;

    typedef struct packed {
        logic [1:0]       kind;
        logic [15:0]      a;
        logic [15:0]      b;
        logic [CNT_W-1:0] thr;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{kind: 2'd1, a: 16'd3,      b: 16'h00FF, thr: 3'd3},
        '{kind: 2'd1, a: 16'd5,      b: 16'h003F, thr: 3'd2},
        '{kind: 2'd0, a: 16'h1d35,   b: 16'h0777, thr: 3'd2},
        '{kind: 2'd0, a: 16'h0013,   b: 16'h0101, thr: 3'd7},
        '{kind: 2'd3, a: 16'd2,      b: 16'h0000, thr: 3'd3},
        '{kind: 2'd3, a: 16'd9,      b: 16'h0000, thr: 3'd5},
        '{kind: 2'd3, a: 16'd4,      b: 16'h0003, thr: 3'd5},
        '{kind: 2'd2, a: 16'd0,      b: 16'h0000, thr: 3'd7}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] thresh = '0;
    logic             buf_rd_en, buf_wr_en, done;
    logic [AW-1:0]    buf_rd_addr, buf_wr_addr;
    logic [DW-1:0]    buf_rd_data, buf_wr_data, zero_planes;

    logic [DW-1:0] mem  [N];
    logic [DW-1:0] orig [N];
    int            wr_cnt;
    int            late_wr;
    logic          after_done;
    int            checks = 0;
    int            errors = 0;
    int            cycles = 0;

    always #10 clk = ~clk;

    bit_plane_eraser #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .CNT_W(CNT_W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .thresh      (thresh),
        .buf_rd_en   (buf_rd_en),
        .buf_rd_addr (buf_rd_addr),
        .buf_rd_data (buf_rd_data),
        .buf_wr_en   (buf_wr_en),
        .buf_wr_addr (buf_wr_addr),
        .buf_wr_data (buf_wr_data),
        .done        (done),
        .zero_planes (zero_planes)
    );

    // synchronous buffer model, one cycle read latency (R10)
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (buf_rd_en) buf_rd_data <= mem[buf_rd_addr];
        if (buf_wr_en) begin
            mem[buf_wr_addr] <= buf_wr_data;
            wr_cnt  <= wr_cnt + 1;
            if (after_done) late_wr <= late_wr + 1;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(logic [1:0] kind, logic [15:0] a, logic [15:0] b, int i);
        logic [15:0] v;
        case (kind)
            2'd0: v = 16'(a * 16'(i + 1) + b) ^ 16'(i << 9);
            2'd1: begin
                v = 16'(16'(i) * a) & b;
                if (i == 3) v = v | 16'h4000;
                if (i == 7 || i == 8) v = v | 16'h8000;
            end
            2'd2: v = 16'hFFFF;
            default: v = (i < int'(a)) ? (16'hA000 | b) : b;
        endcase
        return v;
    endfunction

    // expected mask from R3, R4, R5
    function automatic logic [15:0] model(logic [CNT_W-1:0] thr);
        logic [15:0] m = '0;
        for (int p = DW - 1; p >= 0; p--) begin
            int c = 0;
            for (int i = 0; i < N; i++) if (orig[i][p]) c++;
            if (c > CMAX) c = CMAX;
            if (c < int'(thr)) m[p] = 1'b1;
            else break;
        end
        return m;
    endfunction

    task automatic load(logic [1:0] kind, logic [15:0] a, logic [15:0] b);
        for (int i = 0; i < N; i++) begin
            mem[i]  = pat(kind, a, b, i);
            orig[i] = mem[i];
        end
    endtask

    // one run; disturb changes thresh and re-pulses start while busy (R2)
    task automatic run(logic [CNT_W-1:0] thr, bit disturb, logic [15:0] exp_mask, string tag);
        int  n = 0;
        bit  seen = 0;
        bit  wpulsed = 0;
        int  bad = 0;
        @(negedge clk);
        wr_cnt = 0; late_wr = 0; after_done = 0;
        thresh = thr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) thresh = ~thr;
        while (!seen && n < 5000) begin
            if (disturb) begin
                start = (n == 4) || (buf_wr_en && !wpulsed);
                if (buf_wr_en) wpulsed = 1;
            end
            if (done) seen = 1;
            else begin
                @(negedge clk);
                n++;
            end
        end
        start = 1'b0;
        if (!seen) begin
            errors++; checks++;
            $display("FAIL R8 %s: got no done expected done", tag);
            return;
        end
        check({"R6 mask ", tag}, 32'(zero_planes), 32'(exp_mask));
        after_done = 1;
        @(negedge clk);
        check({"R8 pulse ", tag}, 32'(done), 32'd0);
        for (int i = 0; i < N; i++)
            if (mem[i] !== (orig[i] & ~exp_mask)) bad++;
        check({"R7 data ", tag}, 32'(bad), 32'd0);
        check({"R7 writes ", tag}, 32'(wr_cnt), (exp_mask != 0) ? 32'(N) : 32'd0);
        repeat (3) @(negedge clk);
        check({"R8 late ", tag}, 32'(late_wr), 32'd0);
        check({"R6 hold ", tag}, 32'(zero_planes), 32'(exp_mask));
    endtask

    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) mem[i] = '0;
        wr_cnt = 0; late_wr = 0; after_done = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 done",  32'(done), 32'd0);
        check("R1 rd_en", 32'(buf_rd_en), 32'd0);
        check("R1 wr_en", 32'(buf_wr_en), 32'd0);
        check("R1 mask",  32'(zero_planes), 32'd0);

        // R3 R4 R5 table walk
        for (int v = 0; v < NV; v++) begin
            load(VECS[v].kind, VECS[v].a, VECS[v].b);
            run(VECS[v].thr, 1'b0, model(VECS[v].thr), $sformatf("R3 vec%0d", v));
        end

        // R5: full plane of 16 ones saturates at 7, nothing erased
        load(2'd2, 16'd0, 16'd0);
        run(3'd7, 1'b0, 16'h0000, "R5 saturate");

        // R9: threshold zero erases nothing
        load(2'd1, 16'd3, 16'h00FF);
        run(3'd0, 1'b0, 16'h0000, "R9 zero thr");

        // R9: empty buffer, every plane erased
        load(2'd3, 16'd0, 16'h0000);
        run(3'd1, 1'b0, 16'hFFFF, "R9 all planes");

        // R4: sparse plane 15, dense plane 14, sparse plane 13 kept
        for (int i = 0; i < N; i++) begin
            mem[i] = 16'h4000 | ((i == 2) ? 16'h8000 : 16'h0) | ((i == 9) ? 16'h2000 : 16'h0);
            orig[i] = mem[i];
        end
        run(3'd2, 1'b0, 16'h8000, "R4 stop");

        // R2: threshold change and repeated start during a run
        load(2'd1, 16'd3, 16'h00FF);
        run(3'd3, 1'b1, model(3'd3), "R2 disturb");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule